// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node of a directory coherence scheme. It keeps the state of a small set of memory blocks that several processor caches share. Caches send it three kinds of request: a read miss, a write miss, or the return of a modified block. Each request names the sending processor and a block index. The controller keeps one directory entry per block, plus that block's data in local storage. An entry holds a three-way state (not cached, cached read-only by a set of processors, or owned modified by exactly one processor) and one presence bit per processor.

The controller works on one request at a time. While it is busy it holds `req_ready` low. To serve a request it may send invalidates to the current sharers, or ask the current owner to return the block. The owner can either keep a read-only copy or drop its copy. The request always ends with a reply to the requester. Outgoing messages appear on a single output channel, at most one per cycle. The owner returns data on the `wb_valid`/`wb_data` input.

Top module: `home_dir`

## Requirements
- R1: After reset, every entry is not cached with no presence bits set, all block data is zero, `req_ready` is high and `msg_valid` is low.
- R2: A read miss (`req_kind`=0) to a not-cached block produces one data reply (`msg_kind`=4) to the requester carrying the stored block. The entry becomes read-shared with only the requester present.
- R3: A write miss (`req_kind`=1) to a not-cached block produces a data reply with the stored block. The entry becomes owned by the requester.
- R4: A read miss to a read-shared block produces a data reply with the stored block. The requester is added to the presence bits and the existing sharers are kept.
- R5: A write miss to a read-shared block sends one invalidate (`msg_kind`=1) to every present processor except the requester, then a data reply. The entry becomes owned by the requester alone.
- R6: A read miss to an owned block sends a fetch (`msg_kind`=2) to the owner and waits for `wb_valid`. The returned value is stored, and that value is sent as the data reply. The entry becomes read-shared with both the old owner and the requester present.
- R7: A write miss to an owned block sends a fetch-and-drop (`msg_kind`=3) to the owner. The returned value is stored and then replied to the requester, which becomes the sole owner.
- R8: A block return (`req_kind`=2) from the owner of an owned block stores `req_data` and clears all presence bits, leaving the block not cached. A return from any other processor, a return for a block that is not owned, and the unused kind 3 all change nothing. Every one of these requests receives an acknowledge (`msg_kind`=5, data 0).
- R9: Once a request is accepted, `req_ready` stays low until its reply. A `wb_valid` pulse given before the controller waits for returned data is ignored.
- R10: Invalidates go out one per cycle, in strictly ascending processor number.
- R11: Every request gets exactly one reply or acknowledge, addressed to its requester. `req_ready` returns high in the cycle after that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 block return, 3 unused |
| req_pid | input | PID_W | Requesting processor |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Block value carried by a block return |
| wb_valid | input | 1 | Owner's returned block is present |
| wb_data | input | DATA_W | Owner's returned block value |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_kind | output | 3 | 1 invalidate, 2 fetch, 3 fetch-and-drop, 4 data reply, 5 acknowledge |
| msg_dest | output | PID_W | Destination processor |
| msg_data | output | DATA_W | Block value for replies, zero otherwise |

## Verification
The bench uses the defaults: four processors, four blocks and eight-bit data. At this size, every combination of entry state, request kind and requester identity comes up many times in a long pseudo-random sweep. That includes full sharer sets, where a write miss must skip the requester among three invalidates. It also includes requesters that already own or share the block, and returns from non-owners. Four blocks also let interleaved traffic show whether one entry's update leaks into another.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;

   typedef enum logic [1:0] {
      DIR_UNC = 2'd0,
      DIR_SHR = 2'd1,
      DIR_EXC = 2'd2
   } dir_state_e;

   localparam logic [1:0] REQ_RD = 2'd0;
   localparam logic [1:0] REQ_WR = 2'd1;
   localparam logic [1:0] REQ_WB = 2'd2;

   localparam logic [2:0] MSG_NONE      = 3'd0;
   localparam logic [2:0] MSG_INV       = 3'd1;
   localparam logic [2:0] MSG_FETCH     = 3'd2;
   localparam logic [2:0] MSG_FETCH_INV = 3'd3;
   localparam logic [2:0] MSG_DATA      = 3'd4;
   localparam logic [2:0] MSG_ACK       = 3'd5;

   typedef enum logic [2:0] {
      FSM_IDLE   = 3'd0,
      FSM_DECIDE = 3'd1,
      FSM_INVAL  = 3'd2,
      FSM_WAIT   = 3'd3,
      FSM_REPLY  = 3'd4
   } fsm_e;

endpackage

// File: rtl/home_dir_pick.sv
module home_dir_pick #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [N-1:0] vec,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/home_dir_store.sv
module home_dir_store
   import home_dir_pkg::*;
#(
   parameter int N_PROC = 4,
   parameter int N_BLKS = 4,
   parameter int DATA_W = 8,
   parameter int BLK_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BLK_W-1:0]  rd_blk,
   output dir_state_e        rd_state,
   output logic [N_PROC-1:0] rd_sharers,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ent_we,
   input  dir_state_e        ent_state,
   input  logic [N_PROC-1:0] ent_sharers,
   input  logic              mem_we,
   input  logic [DATA_W-1:0] mem_wdata
);
   dir_state_e        st_q  [N_BLKS];
   logic [N_PROC-1:0] sh_q  [N_BLKS];
   logic [DATA_W-1:0] mem_q [N_BLKS];

   for (genvar b = 0; b < N_BLKS; b++) begin : g_blk
      logic hit;
      assign hit = (rd_blk == BLK_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q[b]  <= DIR_UNC;
            sh_q[b]  <= '0;
            mem_q[b] <= '0;
         end else begin
            if (ent_we && hit) begin
               st_q[b] <= ent_state;
               sh_q[b] <= ent_sharers;
            end
            if (mem_we && hit) mem_q[b] <= mem_wdata;
         end
      end
   end

   assign rd_state   = st_q[rd_blk];
   assign rd_sharers = sh_q[rd_blk];
   assign rd_data    = mem_q[rd_blk];
endmodule

// File: rtl/home_dir_fsm.sv
module home_dir_fsm
   import home_dir_pkg::*;
#(
   parameter int N_PROC = 4,
   parameter int DATA_W = 8,
   parameter int PID_W  = 2,
   parameter int BLK_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [PID_W-1:0]  req_pid,
   input  logic [BLK_W-1:0]  req_blk,
   input  logic [DATA_W-1:0] req_data,
   input  logic              wb_valid,
   input  logic [DATA_W-1:0] wb_data,
   output logic [BLK_W-1:0]  cur_blk,
   input  dir_state_e        rd_state,
   input  logic [N_PROC-1:0] rd_sharers,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [PID_W-1:0]  owner_idx,
   output logic [N_PROC-1:0] pend_vec,
   input  logic              inv_any,
   input  logic [PID_W-1:0]  inv_idx,
   output logic              ent_we,
   output dir_state_e        ent_state,
   output logic [N_PROC-1:0] ent_sharers,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              msg_valid,
   output logic [2:0]        msg_kind,
   output logic [PID_W-1:0]  msg_dest,
   output logic [DATA_W-1:0] msg_data
);
   fsm_e              state_q, state_d;
   logic [1:0]        kind_q;
   logic [PID_W-1:0]  pid_q;
   logic [BLK_W-1:0]  blk_q;
   logic [DATA_W-1:0] data_q;
   logic [N_PROC-1:0] pend_q, pend_d;
   logic [N_PROC-1:0] req_bit;

   assign req_bit  = N_PROC'(1) << pid_q;
   assign cur_blk  = blk_q;
   assign pend_vec = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FSM_IDLE;
         kind_q  <= REQ_RD;
         pid_q   <= '0;
         blk_q   <= '0;
         data_q  <= '0;
         pend_q  <= '0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
         if (state_q == FSM_IDLE && req_valid) begin
            kind_q <= req_kind;
            pid_q  <= req_pid;
            blk_q  <= req_blk;
            data_q <= req_data;
         end
      end
   end

   always_comb begin
      state_d     = state_q;
      pend_d      = pend_q;
      req_ready   = 1'b0;
      ent_we      = 1'b0;
      ent_state   = rd_state;
      ent_sharers = rd_sharers;
      mem_we      = 1'b0;
      mem_wdata   = wb_data;
      msg_valid   = 1'b0;
      msg_kind    = MSG_NONE;
      msg_dest    = pid_q;
      msg_data    = '0;
      case (state_q)
         FSM_IDLE: begin
            req_ready = 1'b1;
            if (req_valid) state_d = FSM_DECIDE;
         end
         FSM_DECIDE: begin
            case (kind_q)
               REQ_RD: begin
                  case (rd_state)
                     DIR_SHR: begin
                        msg_valid   = 1'b1;
                        msg_kind    = MSG_DATA;
                        msg_data    = rd_data;
                        ent_we      = 1'b1;
                        ent_sharers = rd_sharers | req_bit;
                        state_d     = FSM_IDLE;
                     end
                     DIR_EXC: begin
                        msg_valid = 1'b1;
                        msg_kind  = MSG_FETCH;
                        msg_dest  = owner_idx;
                        state_d   = FSM_WAIT;
                     end
                     default: begin
                        msg_valid   = 1'b1;
                        msg_kind    = MSG_DATA;
                        msg_data    = rd_data;
                        ent_we      = 1'b1;
                        ent_state   = DIR_SHR;
                        ent_sharers = req_bit;
                        state_d     = FSM_IDLE;
                     end
                  endcase
               end
               REQ_WR: begin
                  case (rd_state)
                     DIR_SHR: begin
                        pend_d  = rd_sharers & ~req_bit;
                        state_d = FSM_INVAL;
                     end
                     DIR_EXC: begin
                        msg_valid = 1'b1;
                        msg_kind  = MSG_FETCH_INV;
                        msg_dest  = owner_idx;
                        state_d   = FSM_WAIT;
                     end
                     default: begin
                        msg_valid   = 1'b1;
                        msg_kind    = MSG_DATA;
                        msg_data    = rd_data;
                        ent_we      = 1'b1;
                        ent_state   = DIR_EXC;
                        ent_sharers = req_bit;
                        state_d     = FSM_IDLE;
                     end
                  endcase
               end
               REQ_WB: begin
                  msg_valid = 1'b1;
                  msg_kind  = MSG_ACK;
                  if (rd_state == DIR_EXC && rd_sharers == req_bit) begin
                     ent_we      = 1'b1;
                     ent_state   = DIR_UNC;
                     ent_sharers = '0;
                     mem_we      = 1'b1;
                     mem_wdata   = data_q;
                  end
                  state_d = FSM_IDLE;
               end
               default: begin
                  msg_valid = 1'b1;
                  msg_kind  = MSG_ACK;
                  state_d   = FSM_IDLE;
               end
            endcase
         end
         FSM_INVAL: begin
            msg_valid = 1'b1;
            if (inv_any) begin
               msg_kind = MSG_INV;
               msg_dest = inv_idx;
               pend_d   = pend_q & ~(N_PROC'(1) << inv_idx);
            end else begin
               msg_kind    = MSG_DATA;
               msg_data    = rd_data;
               ent_we      = 1'b1;
               ent_state   = DIR_EXC;
               ent_sharers = req_bit;
               state_d     = FSM_IDLE;
            end
         end
         FSM_WAIT: begin
            if (wb_valid) begin
               mem_we  = 1'b1;
               state_d = FSM_REPLY;
            end
         end
         FSM_REPLY: begin
            msg_valid = 1'b1;
            msg_kind  = MSG_DATA;
            msg_data  = rd_data;
            ent_we    = 1'b1;
            if (kind_q == REQ_RD) begin
               ent_state   = DIR_SHR;
               ent_sharers = rd_sharers | req_bit;
            end else begin
               ent_state   = DIR_EXC;
               ent_sharers = req_bit;
            end
            state_d = FSM_IDLE;
         end
         default: state_d = FSM_IDLE;
      endcase
   end
endmodule

// File: rtl/home_dir.sv
module home_dir
   import home_dir_pkg::*;
#(
   parameter int N_PROC = 4,
   parameter int N_BLKS = 4,
   parameter int DATA_W = 8,
   localparam int PID_W = $clog2(N_PROC),
   localparam int BLK_W = $clog2(N_BLKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [PID_W-1:0]  req_pid,
   input  logic [BLK_W-1:0]  req_blk,
   input  logic [DATA_W-1:0] req_data,
   input  logic              wb_valid,
   input  logic [DATA_W-1:0] wb_data,
   output logic              msg_valid,
   output logic [2:0]        msg_kind,
   output logic [PID_W-1:0]  msg_dest,
   output logic [DATA_W-1:0] msg_data
);
   if (N_PROC < 2 || (1 << PID_W) != N_PROC) begin : g_bad_proc
      $error("home_dir: N_PROC must be a power of two and at least 2");
   end
   if (N_BLKS < 2 || (1 << BLK_W) != N_BLKS) begin : g_bad_blks
      $error("home_dir: N_BLKS must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("home_dir: DATA_W must be positive");
   end

   logic [BLK_W-1:0]  cur_blk;
   dir_state_e        rd_state;
   logic [N_PROC-1:0] rd_sharers;
   logic [DATA_W-1:0] rd_data;
   logic              ent_we;
   dir_state_e        ent_state;
   logic [N_PROC-1:0] ent_sharers;
   logic              mem_we;
   logic [DATA_W-1:0] mem_wdata;
   logic [N_PROC-1:0] pend_vec;
   logic              inv_any;
   logic [PID_W-1:0]  inv_idx;
   logic              own_any;
   logic [PID_W-1:0]  owner_idx;

   home_dir_store #(
      .N_PROC(N_PROC), .N_BLKS(N_BLKS), .DATA_W(DATA_W), .BLK_W(BLK_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .rd_blk(cur_blk),
      .rd_state(rd_state), .rd_sharers(rd_sharers), .rd_data(rd_data),
      .ent_we(ent_we), .ent_state(ent_state), .ent_sharers(ent_sharers),
      .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   home_dir_pick #(.N(N_PROC), .W(PID_W)) u_owner (
      .vec(rd_sharers), .any(own_any), .idx(owner_idx)
   );

   home_dir_pick #(.N(N_PROC), .W(PID_W)) u_inval (
      .vec(pend_vec), .any(inv_any), .idx(inv_idx)
   );

   home_dir_fsm #(
      .N_PROC(N_PROC), .DATA_W(DATA_W), .PID_W(PID_W), .BLK_W(BLK_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_pid(req_pid), .req_blk(req_blk), .req_data(req_data),
      .wb_valid(wb_valid), .wb_data(wb_data),
      .cur_blk(cur_blk), .rd_state(rd_state), .rd_sharers(rd_sharers),
      .rd_data(rd_data), .owner_idx(owner_idx),
      .pend_vec(pend_vec), .inv_any(inv_any), .inv_idx(inv_idx),
      .ent_we(ent_we), .ent_state(ent_state), .ent_sharers(ent_sharers),
      .mem_we(mem_we), .mem_wdata(mem_wdata),
      .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
      .msg_data(msg_data)
   );

   logic unused_own;
   assign unused_own = own_any;
endmodule

// File: rtl/home_dir_chk.sv
module home_dir_chk
   import home_dir_pkg::*;
#(
   parameter int PID_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [PID_W-1:0] req_pid,
   input logic             msg_valid,
   input logic [2:0]       msg_kind,
   input logic [PID_W-1:0] msg_dest
);
   logic [PID_W-1:0] cap_pid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_pid <= '0;
      else if (req_valid && req_ready) cap_pid <= req_pid;
   end

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R9

   AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && (msg_kind == MSG_FETCH || msg_kind == MSG_FETCH_INV) |=> !req_ready); // R9

   AST_INV_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_kind == MSG_INV |-> msg_dest != cap_pid); // R5

   AST_INV_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_kind == MSG_INV && $past(msg_valid && msg_kind == MSG_INV)
      |-> msg_dest > $past(msg_dest)); // R10

   AST_REPLY_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && (msg_kind == MSG_DATA || msg_kind == MSG_ACK) |-> msg_dest == cap_pid); // R11

   AST_READY_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && (msg_kind == MSG_DATA || msg_kind == MSG_ACK) |=> req_ready); // R11

   AST_NO_MSG_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !msg_valid); // R1
endmodule

bind home_dir home_dir_chk #(.PID_W(PID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_pid(req_pid), .msg_valid(msg_valid), .msg_kind(msg_kind),
   .msg_dest(msg_dest)
);

// File: tb/home_dir_bench.sv
module home_dir_bench;
   localparam int NP = 4;
   localparam int NB = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_kind = '0;
   logic [1:0]    req_pid = '0;
   logic [1:0]    req_blk = '0;
   logic [DW-1:0] req_data = '0;
   logic          wb_valid = 1'b0;
   logic [DW-1:0] wb_data = '0;
   logic          msg_valid;
   logic [2:0]    msg_kind;
   logic [1:0]    msg_dest;
   logic [DW-1:0] msg_data;

   always #2 clk = ~clk;

   home_dir #(.N_PROC(NP), .N_BLKS(NB), .DATA_W(DW)) u_home_dir (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_pid(req_pid), .req_blk(req_blk),
      .req_data(req_data), .wb_valid(wb_valid), .wb_data(wb_data),
      .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
      .msg_data(msg_data)
   );

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   // model: 0 not cached, 1 shared, 2 owned
   int m_st [NB];
   int m_sh [NB];
   int m_mem[NB];

   int e_kind[8];
   int e_dest[8];
   int e_data[8];
   int n_exp;
   logic [31:0] lf = 32'h1234_5678;

   task automatic check(input string tag, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push(input int k, input int d, input int v);
      e_kind[n_exp] = k; e_dest[n_exp] = d; e_data[n_exp] = v; n_exp++;
   endtask

   function automatic int low_bit(input int v);
      for (int i = NP - 1; i >= 0; i--) if (v[i]) low_bit = i;
   endfunction

   task automatic run_req(input int k, input int p, input int b, input int d,
                          input int wbv, input int dly);
      string tag;
      int bit_p, i, cyc;
      bit_p = 1 << p;
      n_exp = 0;
      tag = "R11";
      case (k)
         0: begin
            if (m_st[b] == 0) begin
               tag = "R2"; push(4, p, m_mem[b]); m_st[b] = 1; m_sh[b] = bit_p;
            end else if (m_st[b] == 1) begin
               tag = "R4"; push(4, p, m_mem[b]); m_sh[b] |= bit_p;
            end else begin
               tag = "R6"; push(2, low_bit(m_sh[b]), 0); m_mem[b] = wbv;
               push(4, p, wbv); m_st[b] = 1; m_sh[b] |= bit_p;
            end
         end
         1: begin
            if (m_st[b] == 0) begin
               tag = "R3"; push(4, p, m_mem[b]);
            end else if (m_st[b] == 1) begin
               tag = "R5";
               for (int j = 0; j < NP; j++) if (m_sh[b][j] && j != p) push(1, j, 0);
               push(4, p, m_mem[b]);
            end else begin
               tag = "R7"; push(3, low_bit(m_sh[b]), 0); m_mem[b] = wbv;
               push(4, p, wbv);
            end
            m_st[b] = 2; m_sh[b] = bit_p;
         end
         2: begin
            tag = "R8";
            if (m_st[b] == 2 && m_sh[b] == bit_p) begin
               m_mem[b] = d; m_st[b] = 0; m_sh[b] = 0;
            end
            push(5, p, 0);
         end
         default: begin tag = "R8"; push(5, p, 0); end
      endcase

      @(negedge clk);
      check("R11", "ready before request", int'(req_ready), 1);
      check("R11", "no message while idle", int'(msg_valid), 0);
      req_valid = 1'b1; req_kind = 2'(k); req_pid = 2'(p); req_blk = 2'(b);
      req_data = DW'(d);
      @(negedge clk);
      req_valid = 1'b0;
      i = 0; cyc = 0;
      while (i < n_exp && cyc < 60) begin
         cyc++;
         if (msg_valid) begin
            check(tag, "message kind", int'(msg_kind), e_kind[i]);
            check(tag, "message dest", int'(msg_dest), e_dest[i]);
            check(tag, "message data", int'(msg_data), e_data[i]);
            if (e_kind[i] == 1 || e_kind[i] == 4 || e_kind[i] == 5)
               check("R11", "ready while busy", int'(req_ready), 0);
            i++;
            if (msg_kind == 3'd2 || msg_kind == 3'd3) begin
               wb_valid = 1'b1; wb_data = DW'(~wbv);
               @(negedge clk);
               wb_valid = 1'b0;
               check("R9", "ready while waiting", int'(req_ready), 0);
               check("R9", "no message while waiting", int'(msg_valid), 0);
               repeat (dly) @(negedge clk);
               wb_valid = 1'b1; wb_data = DW'(wbv);
               @(negedge clk);
               wb_valid = 1'b0;
            end else begin
               @(negedge clk);
            end
         end else begin
            @(negedge clk);
         end
      end
      if (i < n_exp) check(tag, "messages received", i, n_exp);
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : main
      for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_sh[b] = 0; m_mem[b] = 0; end
      repeat (3) @(negedge clk);
      check("R1", "ready in reset", int'(req_ready), 1);
      check("R1", "message in reset", int'(msg_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ready after reset", int'(req_ready), 1);
      check("R1", "message after reset", int'(msg_valid), 0);
      // R1: every block reads back zero from a fresh directory
      for (int b = 0; b < NB; b++) run_req(0, b, b, 0, 0, 0);
      // R3 R8: owned then returned
      run_req(1, 1, 0, 0, 0, 0);
      run_req(2, 1, 0, 8'h10, 0, 0);
      run_req(0, 2, 0, 0, 0, 0);
      // R5 R10: full sharer set, writer in the middle
      for (int p = 0; p < NP; p++) run_req(0, p, 1, 0, 0, 0);
      run_req(1, 2, 1, 0, 0, 1);
      // R6: read of owned block, old owner stays
      run_req(0, 0, 1, 0, 8'h5A, 2);
      // R7: write of owned block
      run_req(1, 3, 2, 0, 0, 0);
      run_req(1, 0, 2, 0, 8'hC3, 0);
      // R8: return from non-owner and unused kind change nothing
      run_req(2, 1, 2, 8'hEE, 0, 0);
      run_req(3, 1, 2, 8'hEE, 0, 0);
      run_req(0, 1, 2, 0, 8'h77, 1);
      // sweep
      for (int n = 0; n < 2500; n++) begin
         int k;
         lf = nxt(lf);
         k = (lf[2:0] < 3) ? 0 : (lf[2:0] < 6) ? 1 : (lf[2:0] == 6) ? 2 : 3;
         run_req(k, int'(lf[5:4]), int'(lf[9:8]), int'(lf[23:16]),
                 int'(lf[31:24]), int'(lf[13:12]));
      end
      @(negedge clk);
      check("R11", "ready at end", int'(req_ready), 1);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule